// File: doc/BRIEF.md
# Tunable Phase Generator with Sample Resizing

This block is the front end of a direct digital synthesis chain. A phase register advances by a programmable tuning word on every enabled clock and wraps modulo 2^PHASE_W. The phase leaves the block so that an external sine generator can turn it into a sample. That generator is a free-running pipeline. Its sample comes back into the block a fixed number of cycles later and is resized there to an output width chosen by parameter.

The block carries a valid flag next to the phase. The flag is delayed by the generator latency, so a returning sample is taken only when it belongs to a phase that was really issued. Two generator kinds can be selected. Kind 0, a polynomial generator, has a latency of POLY_LAT cycles. Kind 1, an iterative rotation generator, has a latency of SINE_W+2 cycles. Only the latency changes with the kind, and the rest of the datapath is the same for both.

When the output is narrower than the sample, the dropped bits are rounded half to even and the result saturates at the positive maximum. When the output is wider, the sample is padded with zeros on the right.

Top module: `dds_front`

## Requirements
- R1: While rst_n is low, phase_out, phase_valid, sample_out and sample_valid are all zero.
- R2: The first enabled cycle after reset, and any enabled cycle with restart high, loads phase_offset into phase_out one clock later. A restart while disabled makes the next enabled cycle load the offset.
- R3: Every other enabled cycle sets phase_out to phase_out + tune_word modulo 2^PHASE_W one clock later. phase_valid is high in the cycle after every enabled cycle.
- R4: In a cycle after enable was low, phase_out keeps its value and phase_valid is low. Once no issued phase remains in flight, sample_valid stays low and sample_out keeps its last value.
- R5: sample_valid goes high exactly LAT+1 cycles after each phase_valid cycle, one result per phase and in order. LAT is POLY_LAT for GEN_KIND 0 and SINE_W+2 for GEN_KIND 1. The result is built from sine_in as sampled LAT cycles after that phase appeared.
- R6: When OUT_W < SINE_W, sample_out is the two's-complement value sine_in / 2^(SINE_W-OUT_W), rounded to the nearest integer, with exact ties going to the even result.
- R7: When rounding a narrowed sample would exceed the largest positive OUT_W value (0111..1), sample_out saturates at that value.
- R8: When OUT_W > SINE_W, sample_out holds sine_in in its upper SINE_W bits and zeros in its lower OUT_W-SINE_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Advance the phase this cycle |
| restart | input | 1 | Reload the phase offset |
| tune_word | input | PHASE_W | Phase increment per enabled cycle |
| phase_offset | input | PHASE_W | Starting phase |
| sine_in | input | SINE_W | Signed sample returned by the generator |
| phase_out | output | PHASE_W | Phase sent to the generator |
| phase_valid | output | 1 | phase_out was issued this cycle |
| sample_out | output | OUT_W | Resized signed sample |
| sample_valid | output | 1 | sample_out is new this cycle |

## Verification
The hardest cases to reach from the ports are the exact rounding ties with odd and even kept parts, and the tie that lands on the positive maximum where rounding must saturate instead of wrapping. The bench plays the role of the generator and returns the delayed phase itself as the sample. Offsets and tuning words can therefore be picked so that the dropped bits land on exact ties, just below and above a tie, and on the top of the positive range. The same stimulus drives a second instance with a wider output, so the zero padding is checked on the same samples.

// File: rtl/dds_pkg.sv
package dds_pkg;
  typedef enum int {
    GEN_POLY = 0,
    GEN_ITER = 1
  } gen_kind_e;

  function automatic int gen_latency(input int kind, input int sin_w, input int poly_lat);
    if (kind == GEN_ITER) return sin_w + 2;
    return poly_lat;
  endfunction
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int PHASE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               restart,
  input  logic [PHASE_W-1:0] tune,
  input  logic [PHASE_W-1:0] offset,
  output logic [PHASE_W-1:0] phase,
  output logic               valid
);
  logic [PHASE_W-1:0] phase_q, phase_d;
  logic               primed_q, primed_d;
  logic               valid_q, valid_d;

  always_comb begin
    phase_d  = phase_q;
    primed_d = primed_q;
    valid_d  = 1'b0;
    if (enable) begin
      valid_d  = 1'b1;
      primed_d = 1'b1;
      if (restart || !primed_q) phase_d = offset;
      else                      phase_d = phase_q + tune;
    end else if (restart) begin
      primed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= '0;
      primed_q <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      primed_q <= primed_d;
      valid_q  <= valid_d;
    end
  end

  assign phase = phase_q;
  assign valid = valid_q;

  // R2: a load cycle puts the offset on the phase
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && (restart || !primed_q)) |=> (phase_q == $past(offset)));

  // R3: a plain enabled cycle advances by the tuning word
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !restart && primed_q) |=> (phase_q == $past(phase_q + tune)));

  // R4: a disabled cycle freezes the phase and drops the valid
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ($stable(phase_q) && !valid_q));
endmodule

// File: rtl/dds_valid_delay.sv
module dds_valid_delay #(
  parameter int LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vin,
  output logic vout
);
  logic [LAT-1:0] pipe_q, pipe_d;

  generate
    if (LAT == 1) begin : g_one
      always_comb pipe_d = vin;
    end else begin : g_many
      always_comb pipe_d = {pipe_q[LAT-2:0], vin};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign vout = pipe_q[LAT-1];
endmodule

// File: rtl/dds_sample_resize.sv
module dds_sample_resize #(
  parameter int SIN_W = 16,
  parameter int OUT_W = 12
) (
  input  logic [SIN_W-1:0] din,
  output logic [OUT_W-1:0] dout
);
  generate
    if (OUT_W < SIN_W) begin : g_narrow
      localparam int DROP = SIN_W - OUT_W;
      localparam logic [OUT_W-1:0] MAXP = {1'b0, {(OUT_W-1){1'b1}}};
      logic [OUT_W-1:0] keep;
      logic [DROP-1:0]  frac;
      logic [DROP-1:0]  half;
      logic             up;
      always_comb begin
        keep = din[SIN_W-1:DROP];
        frac = din[DROP-1:0];
        half = '0;
        half[DROP-1] = 1'b1;
        up   = (frac > half) || ((frac == half) && keep[0]);
        dout = (up && (keep != MAXP)) ? keep + 1'b1 : keep;
      end
      // R6: result is the kept part or one above it
      always_comb begin
        a_r6_close: assert ((dout == keep) || (dout == keep + 1'b1))
          else $error("narrowed sample off by more than one step");
        // R7: a non-negative input never turns negative
        a_r7_no_wrap: assert (keep[OUT_W-1] || !dout[OUT_W-1])
          else $error("positive sample wrapped to negative");
      end
    end else if (OUT_W > SIN_W) begin : g_wide
      always_comb dout = {din, {(OUT_W-SIN_W){1'b0}}};
    end else begin : g_same
      always_comb dout = din;
    end
  endgenerate
endmodule

// File: rtl/dds_front.sv
module dds_front #(
  parameter int PHASE_W  = 16,
  parameter int SINE_W   = 16,
  parameter int OUT_W    = 12,
  parameter int GEN_KIND = 0,
  parameter int POLY_LAT = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               restart,
  input  logic [PHASE_W-1:0] tune_word,
  input  logic [PHASE_W-1:0] phase_offset,
  input  logic [SINE_W-1:0]  sine_in,
  output logic [PHASE_W-1:0] phase_out,
  output logic               phase_valid,
  output logic [OUT_W-1:0]   sample_out,
  output logic               sample_valid
);
  import dds_pkg::*;
  localparam int LAT = gen_latency(GEN_KIND, SINE_W, POLY_LAT);

  logic             tap;
  logic [OUT_W-1:0] resized;
  logic [OUT_W-1:0] smp_q, smp_d;
  logic             sv_q, sv_d;

  dds_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .enable(enable), .restart(restart),
    .tune(tune_word), .offset(phase_offset),
    .phase(phase_out), .valid(phase_valid)
  );

  dds_valid_delay #(.LAT(LAT)) u_dly (
    .clk(clk), .rst_n(rst_n), .vin(phase_valid), .vout(tap)
  );

  dds_sample_resize #(.SIN_W(SINE_W), .OUT_W(OUT_W)) u_rsz (
    .din(sine_in), .dout(resized)
  );

  always_comb begin
    smp_d = tap ? resized : smp_q;
    sv_d  = tap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '0;
      sv_q  <= 1'b0;
    end else begin
      smp_q <= smp_d;
      sv_q  <= sv_d;
    end
  end

  assign sample_out   = smp_q;
  assign sample_valid = sv_q;

  // R5: a result only follows a matured valid
  a_r5_tap: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> $past(tap));

  // R4: with nothing maturing the output stays quiet
  a_r4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !tap |=> ($stable(sample_out) && !sample_valid));
endmodule

// File: tb/tb_dds_front.sv
module tb_dds_front;
  localparam int CLK_PERIOD = 10;
  localparam int PW  = 16;
  localparam int SW  = 16;
  localparam int OW  = 12;
  localparam int OWW = 20;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          enable, restart;
  logic [PW-1:0] tune_word, phase_offset;
  logic [SW-1:0] sine_in;
  logic [PW-1:0] phase_out, phase_out_w;
  logic          phase_valid, phase_valid_w;
  logic [OW-1:0] sample_out;
  logic [OWW-1:0] sample_out_w;
  logic          sample_valid, sample_valid_w;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [OW-1:0]  exp_q[$];
  logic [OWW-1:0] expw_q[$];
  logic [SW-1:0]  gp [LAT];

  logic [PW-1:0] m_phase;
  bit            m_primed;

  always #(CLK_PERIOD/2) clk = ~clk;

  dds_front #(.PHASE_W(PW), .SINE_W(SW), .OUT_W(OW), .GEN_KIND(0), .POLY_LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .restart(restart),
    .tune_word(tune_word), .phase_offset(phase_offset), .sine_in(sine_in),
    .phase_out(phase_out), .phase_valid(phase_valid),
    .sample_out(sample_out), .sample_valid(sample_valid)
  );

  dds_front #(.PHASE_W(PW), .SINE_W(SW), .OUT_W(OWW), .GEN_KIND(0), .POLY_LAT(LAT)) dut_wide (
    .clk(clk), .rst_n(rst_n), .enable(enable), .restart(restart),
    .tune_word(tune_word), .phase_offset(phase_offset), .sine_in(sine_in),
    .phase_out(phase_out_w), .phase_valid(phase_valid_w),
    .sample_out(sample_out_w), .sample_valid(sample_valid_w)
  );

  // generator stand-in: returns the phase itself after LAT stages
  always @(posedge clk) begin
    gp[0] <= phase_out;
    for (int i = 1; i < LAT; i++) gp[i] <= gp[i-1];
  end
  assign sine_in = gp[LAT-1];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // round half to even by integer arithmetic, saturate at top
  function automatic logic [OW-1:0] model_narrow(input logic [SW-1:0] x);
    int v, q, r, lim;
    v = int'($signed(x));
    q = v >>> (SW-OW);
    r = v - q * (1 << (SW-OW));
    if (r > (1 << (SW-OW-1)) || (r == (1 << (SW-OW-1)) && (q % 2 != 0))) q = q + 1;
    lim = (1 << (OW-1)) - 1;
    if (q > lim) q = lim;
    return q[OW-1:0];
  endfunction

  // one clock of stimulus, driven at a falling edge
  task automatic cyc(input bit en, input bit rs);
    bit loading;
    enable  = en;
    restart = rs;
    loading = en && (rs || !m_primed);
    if (en) begin
      m_phase  = loading ? phase_offset : m_phase + tune_word;
      m_primed = 1;
      exp_q.push_back(model_narrow(m_phase));
      expw_q.push_back({m_phase, {(OWW-SW){1'b0}}});
    end else if (rs) begin
      m_primed = 0;
    end
    @(negedge clk);
    if (loading)
      check(phase_out == m_phase && phase_valid, "R2", phase_out, m_phase);
    else if (en)
      check(phase_out == m_phase && phase_valid, "R3", phase_out, m_phase);
    else
      check(phase_out == m_phase && !phase_valid, "R4", phase_out, m_phase);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && sample_valid) begin
      if (exp_q.size() == 0) check(0, "R5", sample_out, 0);
      else begin
        logic [OW-1:0] e;
        e = exp_q.pop_front();
        if (e == 12'h7FF) check(sample_out == e, "R7", sample_out, e);
        else              check(sample_out == e, "R6", sample_out, e);
      end
    end
    if (rst_n && sample_valid_w) begin
      if (expw_q.size() == 0) check(0, "R8", sample_out_w, 0);
      else begin
        logic [OWW-1:0] ew;
        ew = expw_q.pop_front();
        check(sample_out_w == ew, "R8", sample_out_w, ew);
      end
    end
  end

  task automatic run(input logic [PW-1:0] off, input logic [PW-1:0] tw, input int n, input bit rs);
    phase_offset = off;
    tune_word    = tw;
    for (int i = 0; i < n; i++) cyc(1'b1, (i == 0) && rs);
  endtask

  // disabled stretch: after in-flight items drain, output must stay silent
  task automatic idle(input int n);
    logic [OW-1:0] held;
    for (int i = 0; i < n; i++) begin
      cyc(1'b0, 1'b0);
      if (i == LAT + 1) held = sample_out;
      if (i > LAT + 1)
        check(!sample_valid && sample_out == held, "R4", sample_out, held);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; restart = 1'b0;
    tune_word = '0; phase_offset = '0;
    m_phase = '0; m_primed = 0;
    repeat (3) @(negedge clk);
    check(phase_out == 0 && !phase_valid && sample_out == 0 && !sample_valid,
          "R1", {phase_out, sample_out}, 0);
    check(sample_out_w == 0 && !sample_valid_w, "R1", sample_out_w, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run(16'h0018, 16'h0010, 8, 1'b0);  // R6 ties, odd and even kept parts
    run(16'h0101, 16'h0003, 10, 1'b1); // R6 varied fractions
    run(16'h7FE8, 16'h0008, 5, 1'b1);  // R7 saturation, then sign change
    run(16'h7FF9, 16'h0001, 4, 1'b1);  // R7 above tie near top
    run(16'hFFF0, 16'h0004, 6, 1'b1);  // R3 wrap, negative ties
    idle(LAT + 6);                     // R4
    phase_offset = 16'h1238;
    cyc(1'b0, 1'b1);                   // R2 restart while disabled
    run(16'h1238, 16'h2222, 6, 1'b0);
    run(16'h8008, 16'h0010, 4, 1'b1);  // R6 most negative region
    idle(LAT + 4);
    check(exp_q.size() == 0, "R5", exp_q.size(), 0);
    check(expw_q.size() == 0, "R8", expw_q.size(), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule